// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block counts activity on one input pin. When its 16-bit function is on, it runs in one of two modes. In event mode it adds one for each pin edge of a chosen polarity. In gated mode it adds one for each divide-by-64 time-base tick that arrives while the pin sits at a chosen level, so the count measures how long the pin was active.

Two flags record what happened: an input-edge flag and an overflow flag. Each flag drives its own interrupt request when the matching enable bit is set. Software clears a flag by writing a one to it. When the 16-bit function is off, the two 8-bit halves of the counter act as two independent sub-counters, each gated by its own enable input.

A single byte-wide write port reaches four locations: the control byte, the flag byte, and the two count bytes. The divide-by-64 tick comes from an external prescaler. A tick only has effect while the timer-enable input is high.

Top module: `pulse_acc`

## Requirements
- R1: After reset, the control byte, the count, both flags and both interrupt requests are zero.
- R2: Control is written at address 0. Bit 6 is the 16-bit enable, bit 5 the mode (0 event, 1 gated), bit 4 the polarity, bits 3:2 a stored clock-select field, bit 1 the overflow interrupt enable and bit 0 the edge interrupt enable. Bit 7 always reads as zero.
- R3: In event mode with the 16-bit function on, polarity 0 adds one per falling pin edge and polarity 1 adds one per rising pin edge. This holds whether timer_en is high or low.
- R4: In gated mode with the 16-bit function on, each tick64 pulse adds one only while timer_en is high and the pin is at the active level. The active level is high for polarity 0 and low for polarity 1.
- R5: The input-edge flag (flag byte bit 0) is set by each counted edge in event mode. In gated mode it is set by the edge that ends the gate: falling for polarity 0, rising for polarity 1. It is never set while the 16-bit function is off.
- R6: With the 16-bit function on, the count is one 16-bit value. A low-byte wrap carries into the high byte, and sub_en has no effect.
- R7: The overflow flag (flag byte bit 1) is set when the 16-bit count goes from 0xFFFF to 0x0000.
- R8: With the 16-bit function off, the low byte adds one per rising pin edge when sub_en[0] is set, and the high byte does the same when sub_en[1] is set. Each byte wraps at 8 bits with no carry, and no flag is set.
- R9: Writing a one to a bit of the flag byte (address 1) clears that flag. A set event in the same cycle wins over the clear.
- R10: irq_ovf equals the overflow flag ANDed with control bit 1. irq_edge equals the edge flag ANDed with control bit 0.
- R11: Writes to address 2 load the high count byte and writes to address 3 load the low count byte. A count write suppresses any increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timer_en | input | 1 | Timer enable; qualifies tick64 |
| tick64 | input | 1 | Divide-by-64 time-base pulse |
| pin | input | 1 | Asynchronous accumulator input |
| sub_en | input | 2 | Sub-counter enables used while the 16-bit function is off |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 control, 1 flags, 2 count high, 3 count low) |
| wr_data | input | 8 | Write data |
| ctrl_q | output | 8 | Control byte |
| cnt_q | output | 16 | Count value, high byte from the upper sub-counter |
| edge_flag | output | 1 | Input-edge flag |
| ovf_flag | output | 1 | Overflow flag |
| irq_ovf | output | 1 | Overflow interrupt request |
| irq_edge | output | 1 | Input-edge interrupt request |

## Verification
The bench uses the default parameters: 8-bit sub-counters and a two-stage synchronizer. With those values both wrap points can be reached by preloading a count byte to 0xFF and supplying one more event. The bench sweeps every mode and polarity with edge sequences of several lengths, and runs gated windows both with the timer on and with it off. It also places a count write and a flag clear in the exact cycle that an increment or flag set lands, to check which one takes priority.

// File: rtl/pacc_pkg.sv
package pacc_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_FLAG = 2'd1;
  localparam logic [1:0] ADDR_CNTH = 2'd2;
  localparam logic [1:0] ADDR_CNTL = 2'd3;

  typedef struct packed {
    logic       en;
    logic       mode;
    logic       pol;
    logic [1:0] clksel;
    logic       ovf_ie;
    logic       edge_ie;
  } ctrl_t;
endpackage

// File: rtl/pacc_sync.sv
module pacc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic lvl,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q, chain_d;
  logic              prev_q;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], din};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign lvl  = chain_q[STAGES-1];
  assign rise = lvl & ~prev_q;
  assign fall = ~lvl & prev_q;
endmodule

// File: rtl/pacc_evsel.sv
module pacc_evsel
  import pacc_pkg::*;
(
  input  ctrl_t      ctrl,
  input  logic       lvl,
  input  logic       rise,
  input  logic       fall,
  input  logic       tick64,
  input  logic       timer_en,
  input  logic [1:0] sub_en,
  output logic       inc_wide,
  output logic [1:0] inc_sub,
  output logic       set_edge
);
  logic act_edge;
  logic gate_open;

  always_comb begin
    act_edge  = ctrl.pol ? rise : fall;
    gate_open = (lvl != ctrl.pol);
    inc_wide  = 1'b0;
    inc_sub   = 2'b00;
    set_edge  = 1'b0;
    if (ctrl.en) begin
      set_edge = act_edge;
      if (ctrl.mode) inc_wide = tick64 & timer_en & gate_open;
      else           inc_wide = act_edge;
    end else begin
      inc_sub = sub_en & {2{rise}};
    end
  end
endmodule

// File: rtl/pacc_count.sv
module pacc_count #(
  parameter int SUB_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cascade,
  input  logic               inc_wide,
  input  logic [1:0]         inc_sub,
  input  logic               ld_hi,
  input  logic               ld_lo,
  input  logic [SUB_W-1:0]   ld_val,
  output logic [2*SUB_W-1:0] cnt,
  output logic               wrap
);
  localparam int CW = 2 * SUB_W;

  logic [SUB_W-1:0] hi_q, lo_q, hi_d, lo_d;
  logic [CW-1:0]    sum;
  logic             upd;

  always_comb begin
    hi_d = hi_q;
    lo_d = lo_q;
    wrap = 1'b0;
    sum  = {hi_q, lo_q} + CW'(1);
    if (ld_hi || ld_lo) begin
      if (ld_hi) hi_d = ld_val;
      if (ld_lo) lo_d = ld_val;
    end else if (cascade) begin
      if (inc_wide) begin
        {hi_d, lo_d} = sum;
        wrap         = &{hi_q, lo_q};
      end
    end else begin
      if (inc_sub[0]) lo_d = lo_q + SUB_W'(1);
      if (inc_sub[1]) hi_d = hi_q + SUB_W'(1);
    end
    upd = ld_hi | ld_lo | (cascade & inc_wide) | (~cascade & |inc_sub);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (upd) begin
      hi_q <= hi_d;
      lo_q <= lo_d;
    end
  end

  assign cnt = {hi_q, lo_q};
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pacc_pkg::*;
#(
  parameter int SUB_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               timer_en,
  input  logic               tick64,
  input  logic               pin,
  input  logic [1:0]         sub_en,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [SUB_W-1:0]   wr_data,
  output logic [7:0]         ctrl_q,
  output logic [2*SUB_W-1:0] cnt_q,
  output logic               edge_flag,
  output logic               ovf_flag,
  output logic               irq_ovf,
  output logic               irq_edge
);
  ctrl_t ctrl_r, ctrl_d;
  logic  edge_d, ovf_d, edge_r, ovf_r;
  logic  lvl, rise, fall;
  logic  inc_wide, set_edge, wrap;
  logic [1:0] inc_sub;
  logic  wr_ctrl, wr_flag, ld_hi, ld_lo;

  assign wr_ctrl = wr_en && (wr_addr == ADDR_CTRL);
  assign wr_flag = wr_en && (wr_addr == ADDR_FLAG);
  assign ld_hi   = wr_en && (wr_addr == ADDR_CNTH);
  assign ld_lo   = wr_en && (wr_addr == ADDR_CNTL);

  pacc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin),
    .lvl(lvl), .rise(rise), .fall(fall)
  );

  pacc_evsel u_evsel (
    .ctrl(ctrl_r), .lvl(lvl), .rise(rise), .fall(fall),
    .tick64(tick64), .timer_en(timer_en), .sub_en(sub_en),
    .inc_wide(inc_wide), .inc_sub(inc_sub), .set_edge(set_edge)
  );

  pacc_count #(.SUB_W(SUB_W)) u_count (
    .clk(clk), .rst_n(rst_n), .cascade(ctrl_r.en),
    .inc_wide(inc_wide), .inc_sub(inc_sub),
    .ld_hi(ld_hi), .ld_lo(ld_lo), .ld_val(wr_data),
    .cnt(cnt_q), .wrap(wrap)
  );

  // Next state: control load, flag set-over-clear
  always_comb begin
    ctrl_d = wr_ctrl ? ctrl_t'(wr_data[6:0]) : ctrl_r;
    edge_d = (edge_r & ~(wr_flag & wr_data[0])) | set_edge;
    ovf_d  = (ovf_r  & ~(wr_flag & wr_data[1])) | wrap;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_r <= '0;
      edge_r <= 1'b0;
      ovf_r  <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_r <= ctrl_d;
      edge_r <= edge_d;
      ovf_r  <= ovf_d;
    end
  end

  assign ctrl_q    = {1'b0, ctrl_r};
  assign edge_flag = edge_r;
  assign ovf_flag  = ovf_r;
  assign irq_ovf   = ovf_r  & ctrl_r.ovf_ie;
  assign irq_edge  = edge_r & ctrl_r.edge_ie;
endmodule

// File: rtl/pacc_chk.sv
module pacc_chk #(
  parameter int SUB_W = 8
) (
  input logic               clk,
  input logic               rst_n,
  input logic               timer_en,
  input logic               tick64,
  input logic [1:0]         sub_en,
  input logic               wr_en,
  input logic [7:0]         ctrl_q,
  input logic [2*SUB_W-1:0] cnt_q,
  input logic               edge_flag,
  input logic               ovf_flag,
  input logic               irq_ovf,
  input logic               irq_edge
);
  // R2: top control bit never set
  a_r2_bit7_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[7] == 1'b0);

  // R4: gated count holds without a qualified tick
  a_r4_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[6] && ctrl_q[5] && !(tick64 && timer_en) && !wr_en) |=> $stable(cnt_q));

  // R5: edge flag only rises when the 16-bit function was on
  a_r5_edge_only_wide: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(edge_flag) |-> $past(ctrl_q[6]));

  // R7: overflow flag rises only with a zero count
  a_r7_ovf_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> (cnt_q == '0));

  // R8: disabled high sub-counter holds
  a_r8_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl_q[6] && !sub_en[1] && !wr_en) |=> $stable(cnt_q[2*SUB_W-1:SUB_W]));

  // R10: interrupt requests follow flag and enable
  a_r10_irq_ovf: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ovf == (ovf_flag && ctrl_q[1]));
  a_r10_irq_edge: assert property (@(posedge clk) disable iff (!rst_n)
    irq_edge == (edge_flag && ctrl_q[0]));
endmodule

bind pulse_acc pacc_chk #(.SUB_W(SUB_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .tick64(tick64),
  .sub_en(sub_en), .wr_en(wr_en), .ctrl_q(ctrl_q), .cnt_q(cnt_q),
  .edge_flag(edge_flag), .ovf_flag(ovf_flag),
  .irq_ovf(irq_ovf), .irq_edge(irq_edge)
);

// File: tb/sim_pulse_acc.sv
module sim_pulse_acc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        timer_en = 1'b0, tick64 = 1'b0, pin = 1'b0;
  logic [1:0]  sub_en = 2'b00;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'b00;
  logic [7:0]  wr_data = 8'h00;
  logic [7:0]  ctrl_q;
  logic [15:0] cnt_q;
  logic        edge_flag, ovf_flag, irq_ovf, irq_edge;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pulse_acc u0 (
    .clk(clk), .rst_n(rst_n), .timer_en(timer_en), .tick64(tick64), .pin(pin),
    .sub_en(sub_en), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .ctrl_q(ctrl_q), .cnt_q(cnt_q), .edge_flag(edge_flag), .ovf_flag(ovf_flag),
    .irq_ovf(irq_ovf), .irq_edge(irq_edge)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick64 = 1'b1;
      @(negedge clk); tick64 = 1'b0;
    end
  endtask

  task automatic load(input logic [15:0] v);
    wr(2'd2, v[15:8]); wr(2'd3, v[7:0]);
  endtask

  task automatic finish_sim;
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_sim();
  end

  initial begin
    int exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ctrl_q, 0, "R1 ctrl"); chk(cnt_q, 0, "R1 cnt");
    chk({edge_flag, ovf_flag, irq_ovf, irq_edge}, 0, "R1 flags/irqs");

    // R2 layout and bit 7
    wr(2'd0, 8'hFF); chk(ctrl_q, 8'h7F, "R2 readback");
    wr(2'd0, 8'h0C); chk(ctrl_q, 8'h0C, "R2 clksel");
    wr(2'd0, 8'h00);

    // R3/R5/R6 event sweep, timer off, sub_en ignored
    timer_en = 1'b0; sub_en = 2'b11;
    for (int pol = 0; pol < 2; pol++) begin
      for (int n = 1; n <= 7; n += 3) begin
        wr(2'd0, 8'h00); set_pin(1'b0);
        load(16'h0000); wr(2'd1, 8'h03);
        wr(2'd0, 8'h40 | 8'(pol << 4));
        exp = 0;
        for (int t = 0; t < 2 * n; t++) begin
          set_pin(~pin);
          if ((pol == 1) == (pin == 1'b1)) exp++;
          chk(cnt_q, 16'(exp), "R3 event count");
          chk(edge_flag, (exp > 0), "R5 event edge flag");
        end
        chk(cnt_q, 16'(n), "R6 sub_en ignored");
      end
    end

    // R6 carry across bytes
    wr(2'd0, 8'h50); set_pin(1'b0);
    load(16'h12FF); set_pin(1'b1);
    chk(cnt_q, 16'h1300, "R6 carry");

    // R7 overflow, R10 irq, R9 clear
    set_pin(1'b0); load(16'hFFFF); wr(2'd1, 8'h03);
    set_pin(1'b1);
    chk(cnt_q, 16'h0000, "R7 wrap value"); chk(ovf_flag, 1, "R7 ovf flag");
    chk(irq_ovf, 0, "R10 irq_ovf masked"); chk(irq_edge, 0, "R10 irq_edge masked");
    wr(2'd0, 8'h53);
    chk(irq_ovf, 1, "R10 irq_ovf"); chk(irq_edge, 1, "R10 irq_edge");
    wr(2'd1, 8'h02);
    chk(ovf_flag, 0, "R9 ovf cleared"); chk(edge_flag, 1, "R9 edge kept");
    wr(2'd1, 8'h01); chk(edge_flag, 0, "R9 edge cleared");

    // R4/R5 gated sweep
    sub_en = 2'b00;
    for (int pol = 0; pol < 2; pol++) begin
      wr(2'd0, 8'h00); timer_en = 1'b1;
      set_pin(pol[0]);
      load(16'h0000); wr(2'd0, 8'h60 | 8'(pol << 4)); wr(2'd1, 8'h03);
      ticks(5); chk(cnt_q, 0, "R4 inactive level");
      set_pin(~pol[0]);
      chk(edge_flag, 0, "R5 opening edge no flag");
      ticks(5); chk(cnt_q, 5, "R4 active ticks");
      set_pin(pol[0]);
      chk(edge_flag, 1, "R5 closing edge flag"); chk(cnt_q, 5, "R4 hold after gate");
      timer_en = 1'b0; set_pin(~pol[0]);
      ticks(3); chk(cnt_q, 5, "R4 timer off");
      timer_en = 1'b1; ticks(2); chk(cnt_q, 7, "R4 timer on again");
      set_pin(pol[0]);
    end

    // R8 split sub-counters
    wr(2'd0, 8'h00); timer_en = 1'b0; set_pin(1'b0);
    load(16'h0000); wr(2'd1, 8'h03);
    sub_en = 2'b01;
    for (int i = 0; i < 3; i++) begin set_pin(1'b1); set_pin(1'b0); end
    chk(cnt_q, 16'h0003, "R8 low only");
    sub_en = 2'b10;
    for (int i = 0; i < 2; i++) begin set_pin(1'b1); set_pin(1'b0); end
    chk(cnt_q, 16'h0203, "R8 high only");
    sub_en = 2'b01; load(16'h10FF);
    set_pin(1'b1); set_pin(1'b0);
    chk(cnt_q, 16'h1000, "R8 no carry");
    chk({edge_flag, ovf_flag}, 0, "R8 no flags");

    // R11 write beats increment; R9 set beats clear
    sub_en = 2'b00;
    wr(2'd0, 8'h50); load(16'h3344);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h55;
    @(negedge clk); wr_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(cnt_q, 16'h3355, "R11 write priority");
    set_pin(1'b0);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    @(negedge clk); wr_en = 1'b1; wr_addr = 2'd1; wr_data = 8'h01;
    @(negedge clk); wr_en = 1'b0;
    chk(edge_flag, 1, "R9 set wins");
    chk(cnt_q, 16'h3356, "R11 increment after write");

    finish_sim();
  end
endmodule